// File: doc/BRIEF.md
# Translated Instruction Issue Queue

This block sits between a hardware instruction translator and the fetch port of a processor, and it looks to that processor like plain instruction memory. Each time the translator finishes one source instruction it presents the resulting group of up to twelve 32-bit target instructions, together with how many of them are valid. The queue stores the whole group in one clock. The processor then takes them one per fetch, oldest first, and never sees where one group ends and the next begins.

The storage holds twice the largest group. While the older half of the contents is being handed to the processor, a new group can land in the free half. The queue publishes its fill level every cycle and raises a ready signal whenever a full-size group would still fit, so the translator's controller can start on the next source instruction early. When nothing is stored, the queue tells the processor to stall and drives zero on its data output. After the source program counter is redirected, a flush input throws away everything stored in a single cycle.

Top module: `xlat_issue_queue`

## Requirements
- R1: After reset the queue holds nothing: `occupancy` is 0, `stall` is 1, `batchReady` is 1 and `fetchData` is 0.
- R2: A group with `batchValid` high, `batchReady` high and `batchCount` from 1 to 12 is stored in that clock edge; in the next cycle `occupancy` has grown by `batchCount` (minus one if a fetch was taken in the same cycle).
- R3: Word k of a group is carried on `batchData` bits [32k+31:32k]; words leave in index order, and all words of a group leave before any word of a later group. Lanes at or above `batchCount` are not stored.
- R4: When `stall` is 0, `fetchData` shows the oldest stored word; a cycle with `fetchReq` high removes exactly that word, so `occupancy` drops by one.
- R5: `batchReady` is 1 exactly when at least 12 slots are free, that is when `occupancy` is 12 or less.
- R6: A group offered while `batchReady` is 0 is dropped: `occupancy` does not grow and the words later fetched are only those stored before.
- R7: With nothing stored, `stall` is 1, `fetchData` is 0, and `fetchReq` has no effect on `occupancy`.
- R8: A group write and a fetch in the same cycle both take effect: `occupancy` becomes the old value plus `batchCount` minus one, and the fetched word is the old head.
- R9: A cycle with `flush` high empties the queue by the next cycle, taking priority over any group write and fetch in that cycle; the words fetched afterwards are only those written after the flush.
- R10: A group with `batchCount` of 0 or greater than 12 is ignored even when `batchReady` is 1.
- R11: The queue holds up to 24 words, `occupancy` never exceeds 24, and order is kept as the storage position wraps around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all stored words this cycle |
| batchValid | input | 1 | A translated group is offered |
| batchCount | input | 4 | Number of valid words in the group (1 to 12) |
| batchData | input | 384 | Group words, word k at bits [32k+31:32k] |
| batchReady | output | 1 | At least twelve slots are free |
| fetchReq | input | 1 | Processor takes the head word this cycle |
| fetchData | output | 32 | Head word, zero while stalled |
| stall | output | 1 | Queue is empty; processor must wait |
| occupancy | output | 5 | Number of stored words |

## Verification
Every cycle the bound checker confirms that the fill level stays within capacity, that ready agrees with the fill level, that a stalled output carries zero, that a flush empties the queue by the next cycle, and that lone fetches, lone accepted groups and rejected groups move the fill level by exactly the expected amount. What those per-cycle rules cannot show is which word comes out: ordering within and across groups, the exclusion of unused lanes, the dropping of a group offered while full or with an illegal count, and the absence of stale words after a flush and after the storage wraps are shown only by the bench's scenarios, which compare each fetched word against a reference list.

// File: rtl/xiq_pkg.sv
package xiq_pkg;

  // Strobes from the control section to the storage section.
  typedef struct packed {
    logic doWrite;  // store the offered group this edge
    logic doPop;    // retire the head word this edge
    logic doFlush;  // clear every slot this edge
  } xiq_strobe_t;

endpackage

// File: rtl/xiq_ctrl.sv
module xiq_ctrl
  import xiq_pkg::*;
#(
  parameter int MAX_BATCH = 12,
  parameter int DEPTH     = 2 * MAX_BATCH,
  parameter int CNT_W     = $clog2(MAX_BATCH + 1),
  parameter int OCC_W     = $clog2(DEPTH + 1),
  parameter int PTR_W     = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             batchValid,
  input  logic [CNT_W-1:0] batchCount,
  input  logic             fetchReq,
  output xiq_strobe_t      strobe,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [OCC_W-1:0] occupancy,
  output logic             batchReady,
  output logic             stall
);

  localparam logic [OCC_W-1:0] READY_LIMIT = OCC_W'(DEPTH - MAX_BATCH);
  localparam logic [PTR_W:0]   DEPTH_EXT   = (PTR_W + 1)'(DEPTH);
  localparam logic [CNT_W-1:0] MAX_CNT     = CNT_W'(MAX_BATCH);

  logic [OCC_W-1:0] occQ;
  logic [PTR_W-1:0] wrPtrQ;
  logic [PTR_W-1:0] rdPtrQ;
  logic             countOk;
  logic             roomOk;
  logic             emptyNow;
  logic [OCC_W-1:0] addAmt;
  logic [OCC_W-1:0] subAmt;

  function automatic logic [PTR_W-1:0] wrapAdd(input logic [PTR_W-1:0] base,
                                               input logic [PTR_W-1:0] step);
    logic [PTR_W:0] sum;
    sum = {1'b0, base} + {1'b0, step};
    if (sum >= DEPTH_EXT) sum = sum - DEPTH_EXT;
    return sum[PTR_W-1:0];
  endfunction

  always_comb begin
    countOk  = (batchCount != '0) && (batchCount <= MAX_CNT);
    roomOk   = (occQ <= READY_LIMIT);
    emptyNow = (occQ == '0);

    strobe.doFlush = flush;
    strobe.doWrite = !flush && batchValid && roomOk && countOk;
    strobe.doPop   = !flush && fetchReq && !emptyNow;

    addAmt = strobe.doWrite ? OCC_W'(batchCount) : '0;
    subAmt = strobe.doPop   ? OCC_W'(1)          : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occQ   <= '0;
      wrPtrQ <= '0;
      rdPtrQ <= '0;
    end else if (strobe.doFlush) begin
      occQ   <= '0;
      wrPtrQ <= '0;
      rdPtrQ <= '0;
    end else begin
      occQ <= occQ + addAmt - subAmt;
      if (strobe.doWrite) wrPtrQ <= wrapAdd(wrPtrQ, PTR_W'(batchCount));
      if (strobe.doPop)   rdPtrQ <= wrapAdd(rdPtrQ, PTR_W'(1));
    end
  end

  assign wrPtr      = wrPtrQ;
  assign rdPtr      = rdPtrQ;
  assign occupancy  = occQ;
  assign batchReady = roomOk;
  assign stall      = emptyNow;

endmodule

// File: rtl/xiq_datapath.sv
module xiq_datapath
  import xiq_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int MAX_BATCH = 12,
  parameter int DEPTH     = 2 * MAX_BATCH,
  parameter int CNT_W     = $clog2(MAX_BATCH + 1),
  parameter int PTR_W     = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  xiq_strobe_t                 strobe,
  input  logic [PTR_W-1:0]            wrPtr,
  input  logic [PTR_W-1:0]            rdPtr,
  input  logic                        emptyNow,
  input  logic [CNT_W-1:0]            batchCount,
  input  logic [MAX_BATCH*WORD_W-1:0] batchData,
  output logic [WORD_W-1:0]           fetchData
);

  localparam int LANE_W = $clog2(MAX_BATCH);

  logic [WORD_W-1:0] lane     [MAX_BATCH];
  logic [WORD_W-1:0] slotView [DEPTH];

  // Unpack the flat group into lanes.
  for (genvar k = 0; k < MAX_BATCH; k++) begin : g_lane
    assign lane[k] = batchData[k*WORD_W +: WORD_W];
  end

  // Each slot works out which lane (if any) lands in it this edge.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    localparam logic [PTR_W:0] IDX      = (PTR_W + 1)'(i);
    localparam logic [PTR_W:0] IDX_WRAP = (PTR_W + 1)'(i + DEPTH);

    logic [PTR_W:0]    offs;
    logic              hit;
    logic [LANE_W-1:0] laneSel;
    logic [WORD_W-1:0] slotQ;

    always_comb begin
      if (IDX >= {1'b0, wrPtr}) offs = IDX - {1'b0, wrPtr};
      else                      offs = IDX_WRAP - {1'b0, wrPtr};
      hit     = strobe.doWrite && (offs < (PTR_W + 1)'(batchCount));
      laneSel = offs[LANE_W-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                slotQ <= '0;
      else if (strobe.doFlush)  slotQ <= '0;
      else if (hit)             slotQ <= lane[laneSel];
    end

    assign slotView[i] = slotQ;
  end

  assign fetchData = emptyNow ? '0 : slotView[rdPtr];

endmodule

// File: rtl/xlat_issue_queue.sv
module xlat_issue_queue
  import xiq_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int MAX_BATCH = 12,
  parameter int DEPTH     = 2 * MAX_BATCH,
  parameter int CNT_W     = $clog2(MAX_BATCH + 1),
  parameter int OCC_W     = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        flush,
  input  logic                        batchValid,
  input  logic [CNT_W-1:0]            batchCount,
  input  logic [MAX_BATCH*WORD_W-1:0] batchData,
  output logic                        batchReady,
  input  logic                        fetchReq,
  output logic [WORD_W-1:0]           fetchData,
  output logic                        stall,
  output logic [OCC_W-1:0]            occupancy
);

  localparam int PTR_W = $clog2(DEPTH);

  xiq_strobe_t      strobe;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic             emptyNow;

  xiq_ctrl #(
    .MAX_BATCH(MAX_BATCH), .DEPTH(DEPTH), .CNT_W(CNT_W),
    .OCC_W(OCC_W), .PTR_W(PTR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush),
    .batchValid(batchValid), .batchCount(batchCount), .fetchReq(fetchReq),
    .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .occupancy(occupancy), .batchReady(batchReady), .stall(emptyNow)
  );

  xiq_datapath #(
    .WORD_W(WORD_W), .MAX_BATCH(MAX_BATCH), .DEPTH(DEPTH),
    .CNT_W(CNT_W), .PTR_W(PTR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .emptyNow(emptyNow),
    .batchCount(batchCount), .batchData(batchData), .fetchData(fetchData)
  );

  assign stall = emptyNow;

endmodule

// File: rtl/xiq_checker.sv
module xiq_checker #(
  parameter int WORD_W    = 32,
  parameter int MAX_BATCH = 12,
  parameter int DEPTH     = 2 * MAX_BATCH,
  parameter int CNT_W     = $clog2(MAX_BATCH + 1),
  parameter int OCC_W     = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              flush,
  input logic              batchValid,
  input logic [CNT_W-1:0]  batchCount,
  input logic              batchReady,
  input logic              fetchReq,
  input logic [WORD_W-1:0] fetchData,
  input logic              stall,
  input logic [OCC_W-1:0]  occupancy
);

  localparam logic [OCC_W-1:0] CAP   = OCC_W'(DEPTH);
  localparam logic [OCC_W-1:0] LIMIT = OCC_W'(DEPTH - MAX_BATCH);
  localparam logic [CNT_W-1:0] MAXC  = CNT_W'(MAX_BATCH);

  logic legalCount;
  assign legalCount = (batchCount != '0) && (batchCount <= MAXC);

  assert_occ_bound_R11: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= CAP);

  assert_ready_room_R5: assert property (@(posedge clk) disable iff (!rstN)
    batchReady == (occupancy <= LIMIT));

  assert_empty_silent_R7: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (fetchData == '0) && (occupancy == '0));

  assert_flush_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (occupancy == '0) && stall);

  assert_pop_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!flush && fetchReq && !stall && !batchValid)
      |=> occupancy == $past(occupancy) - OCC_W'(1));

  assert_reject_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!flush && batchValid && !batchReady && !fetchReq) |=> $stable(occupancy));

  assert_write_grow_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!flush && batchValid && batchReady && legalCount && !fetchReq)
      |=> occupancy == $past(occupancy) + OCC_W'($past(batchCount)));

  assert_bad_count_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!flush && batchValid && !legalCount && !fetchReq) |=> $stable(occupancy));

endmodule

bind xlat_issue_queue xiq_checker #(
  .WORD_W(WORD_W), .MAX_BATCH(MAX_BATCH), .DEPTH(DEPTH),
  .CNT_W(CNT_W), .OCC_W(OCC_W)
) u_xiq_checker (
  .clk(clk), .rstN(rstN), .flush(flush),
  .batchValid(batchValid), .batchCount(batchCount), .batchReady(batchReady),
  .fetchReq(fetchReq), .fetchData(fetchData), .stall(stall),
  .occupancy(occupancy)
);

// File: tb/xlat_issue_queue_bench.sv
module xlat_issue_queue_bench;

  localparam int W    = 32;
  localparam int MAXB = 12;
  localparam int CAP  = 24;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            flush = 1'b0;
  logic            batchValid = 1'b0;
  logic [3:0]      batchCount = '0;
  logic [MAXB*W-1:0] batchData = '0;
  logic            batchReady;
  logic            fetchReq = 1'b0;
  logic [W-1:0]    fetchData;
  logic            stall;
  logic [4:0]      occupancy;

  int errors = 0;
  int checks = 0;
  logic [W-1:0] model[$];

  always #10 clk = ~clk;  // 50 MHz

  xlat_issue_queue u_xlat_issue_queue (
    .clk(clk), .rstN(rstN), .flush(flush),
    .batchValid(batchValid), .batchCount(batchCount), .batchData(batchData),
    .batchReady(batchReady), .fetchReq(fetchReq), .fetchData(fetchData),
    .stall(stall), .occupancy(occupancy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint actual, input longint expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, actual, expected);
    end
  endtask

  // Compare every output with the reference list, then apply one cycle.
  task automatic step(input string req, input bit v, input int n,
                      input logic [W-1:0] base, input bit fr, input bit fl);
    int sz;
    logic [W-1:0] expData;
    bit acc;
    sz = model.size();
    expData = (sz == 0) ? '0 : model[0];
    check(occupancy == 5'(sz), req, "occupancy", occupancy, sz);
    check(stall == (sz == 0), req, "stall", stall, (sz == 0));
    check(batchReady == (sz <= CAP - MAXB), req, "batchReady", batchReady, (sz <= CAP - MAXB));
    check(fetchData == expData, req, "fetchData", fetchData, expData);
    flush      = fl;
    batchValid = v;
    batchCount = 4'(n);
    fetchReq   = fr;
    for (int k = 0; k < MAXB; k++)
      batchData[k*W +: W] = (k < n) ? base + W'(k) : 32'hBAD0_0000 + W'(k);
    acc = !fl && v && (sz <= CAP - MAXB) && (n >= 1) && (n <= MAXB);
    @(posedge clk);
    if (fl) model.delete();
    else begin
      if (fr && sz > 0) void'(model.pop_front());
      if (acc) for (int k = 0; k < n; k++) model.push_back(base + W'(k));
    end
    @(negedge clk);
    flush = 1'b0; batchValid = 1'b0; fetchReq = 1'b0; batchCount = '0;
  endtask

  task automatic drain(input string req);
    while (model.size() > 0) step(req, 0, 0, '0, 1, 0);
    step(req, 0, 0, '0, 0, 0);
  endtask

  task automatic testReset();
    check(occupancy == 0, "R1", "occupancy", occupancy, 0);
    check(stall == 1'b1, "R1", "stall", stall, 1);
    check(batchReady == 1'b1, "R1", "batchReady", batchReady, 1);
    check(fetchData == '0, "R1", "fetchData", fetchData, 0);
  endtask

  task automatic testSingleBatch();
    step("R2", 1, 3, 32'h1000_0000, 0, 0);
    check(occupancy == 3, "R2", "occ after group of 3", occupancy, 3);
    drain("R3");
    step("R7", 0, 0, '0, 1, 0);  // fetch on empty
    check(occupancy == 0 && stall, "R7", "empty fetch no effect", occupancy, 0);
  endtask

  task automatic testFillAndReject();
    step("R2", 1, 12, 32'h2000_0000, 0, 0);
    step("R5", 1, 12, 32'h2100_0000, 0, 0);
    check(occupancy == 24 && !batchReady, "R11", "full queue", occupancy, 24);
    step("R6", 1, 5, 32'h2F00_0000, 0, 0);
    check(occupancy == 24, "R6", "rejected group", occupancy, 24);
    for (int p = 0; p < 11; p++) step("R4", 0, 0, '0, 1, 0);
    check(!batchReady && occupancy == 13, "R5", "ready low at 13", batchReady, 0);
    step("R4", 0, 0, '0, 1, 0);
    check(batchReady && occupancy == 12, "R5", "ready high at 12", batchReady, 1);
    drain("R3");
  endtask

  task automatic testOverlap();
    step("R2", 1, 2, 32'h3000_0000, 0, 0);
    step("R8", 1, 4, 32'h3100_0000, 1, 0);
    check(occupancy == 5, "R8", "write plus fetch", occupancy, 5);
    drain("R8");
  endtask

  task automatic testBadCount();
    step("R10", 1, 0, 32'h4000_0000, 0, 0);
    step("R10", 1, 13, 32'h4100_0000, 0, 0);
    check(occupancy == 0, "R10", "illegal counts ignored", occupancy, 0);
  endtask

  task automatic testFlush();
    step("R2", 1, 6, 32'h5000_0000, 0, 0);
    step("R9", 1, 3, 32'h5100_0000, 1, 1);
    check(occupancy == 0 && stall, "R9", "flush empties", occupancy, 0);
    step("R9", 1, 2, 32'h5200_0000, 0, 0);
    drain("R9");
  endtask

  task automatic testWrap();
    for (int r = 0; r < 10; r++) begin
      step("R11", 1, 7, 32'h6000_0000 + W'(r << 8), 0, 0);
      for (int p = 0; p < 5; p++) step("R11", 0, 0, '0, 1, 0);
    end
    drain("R11");
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSingleBatch();
    testFillAndReject();
    testOverlap();
    testBadCount();
    testFlush();
    testWrap();
    finishRun();
  end

endmodule